// File: doc/BRIEF.md
# Single-Port RAM with Written-Word Tracking

This block is a single-port random-access memory. Each access is marked by a one-cycle strobe that is sampled on the rising clock edge. A read-not-write select picks the operation. A write stores the input word at the addressed location on the same edge that samples the strobe. A read returns the addressed word on the output bus a fixed, parameterised number of clock edges later. The output then keeps that value until the next read completes.

Alongside the data array, the block keeps one written flag per word. A synchronous reset clears every flag; the data array itself is not cleared. When a read hits a word whose flag is clear, the output bus is driven to all-unknown and the data-valid output is held low. Simulation can therefore spot reads of uninitialised storage, and synthesised logic can detect the same case through the valid bit. The data array has a registered read and no reset, so it maps onto block RAM.

Top module: `sp_tracked_ram`

## Requirements
- R1: When `acc_en` is 1 and `rd_nwr` is 0 (write) at a rising edge, `wr_data` is stored at location `addr`. A later read of that location returns it.
- R2: When `acc_en` is 1 and `rd_nwr` is 1 (read) at rising edge E, `rd_data` and `rd_valid` take the result at edge E+READ_LAT and at no earlier edge.
- R3: A read of a location that has not been written since the last reset gives `rd_valid` = 0, and `rd_data` is driven to all-unknown.
- R4: A read of a location that has been written since reset gives `rd_valid` = 1, and `rd_valid` rises only as the result of such a read.
- R5: After `rst` is asserted, every location counts as unwritten, including locations written before the reset.
- R6: `rd_data` and `rd_valid` hold their values on every edge where no read result is due. This includes idle cycles and write accesses.
- R7: When `acc_en` is 0, nothing is stored, whatever the values of `rd_nwr`, `addr` and `wr_data`.
- R8: While `rst` is 1 and on the first edge after it, `rd_valid` is 0.
- R9: A second write to the same location replaces the first, and a read returns the most recent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; clears all written flags |
| acc_en | input | 1 | One-cycle access strobe |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Word to store on a write |
| rd_data | output | DATA_W | Read result; all-unknown for unwritten words |
| rd_valid | output | 1 | High when the last read hit a written word |

## Verification
A read strobe sampled at edge E changes the outputs at edge E+READ_LAT. The bench drives a read at a falling edge and waits READ_LAT+1 further falling edges before it samples. For the timing requirement, it also samples one falling edge earlier to confirm that the old value is still present. Write results are checked only through later reads, since a write changes no output. For the hold and ignore cases, the outputs are sampled on falling edges after idle or write activity, at a point where no read result could be due. The unknown-data case is judged through the valid output, because a two-state simulator cannot show unknown bits.

// File: rtl/sp_ram_pkg.sv
package sp_ram_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } ram_op_e;

  function automatic int unsigned depth_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/sp_ram_store.sv
module sp_ram_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rq
);
  localparam int unsigned DEPTH = sp_ram_pkg::depth_of(ADDR_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset on the array or the read register so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/sp_ram_flags.sv
module sp_ram_flags #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned DEPTH = sp_ram_pkg::depth_of(ADDR_W);

  logic [DEPTH-1:0] written;

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (we) begin
      written[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
    end else if (re) begin
      hit <= written[addr];
    end
  end
endmodule

// File: rtl/sp_ram_delay.sv
module sp_ram_delay #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_tag,
  input  logic              in_hit,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_tag,
  output logic              out_hit,
  output logic [DATA_W-1:0] out_data
);
  generate
    if (STAGES == 0) begin : g_pass
      assign out_tag  = in_tag;
      assign out_hit  = in_hit;
      assign out_data = in_data;
    end else begin : g_pipe
      logic              tag_q  [STAGES];
      logic              hit_q  [STAGES];
      logic [DATA_W-1:0] data_q [STAGES];

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            tag_q[s] <= 1'b0;
          end else begin
            tag_q[s] <= (s == 0) ? in_tag : tag_q[(s == 0) ? 0 : s-1];
          end
        end
        always_ff @(posedge clk) begin
          if (s == 0) begin
            hit_q[s]  <= in_hit;
            data_q[s] <= in_data;
          end else begin
            hit_q[s]  <= hit_q[(s == 0) ? 0 : s-1];
            data_q[s] <= data_q[(s == 0) ? 0 : s-1];
          end
        end
      end

      assign out_tag  = tag_q[STAGES-1];
      assign out_hit  = hit_q[STAGES-1];
      assign out_data = data_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sp_tracked_ram.sv
module sp_tracked_ram #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned READ_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              rd_nwr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import sp_ram_pkg::*;

  localparam int unsigned EXTRA = (READ_LAT > 1) ? READ_LAT - 1 : 0;

  ram_op_e           op;
  logic              do_wr, do_rd;
  logic              issue_q;
  logic [DATA_W-1:0] mem_q;
  logic              hit_q;
  logic              p_tag, p_hit;
  logic [DATA_W-1:0] p_data;

  assign op    = ram_op_e'(rd_nwr);
  assign do_wr = acc_en && (op == OP_WRITE);
  assign do_rd = acc_en && (op == OP_READ);

  sp_ram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(do_wr), .re(do_rd), .addr(addr), .wd(wr_data), .rq(mem_q)
  );

  sp_ram_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk(clk), .rst(rst), .we(do_wr), .re(do_rd), .addr(addr), .hit(hit_q)
  );

  always_ff @(posedge clk) begin
    if (rst) issue_q <= 1'b0;
    else     issue_q <= do_rd;
  end

  sp_ram_delay #(.DATA_W(DATA_W), .STAGES(EXTRA)) u_delay (
    .clk(clk), .rst(rst),
    .in_tag(issue_q), .in_hit(hit_q), .in_data(mem_q),
    .out_tag(p_tag), .out_hit(p_hit), .out_data(p_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= {DATA_W{1'bx}};
    end else if (p_tag) begin
      rd_valid <= p_hit;
      rd_data  <= p_hit ? p_data : {DATA_W{1'bx}};
    end
  end
endmodule

// File: rtl/sp_tracked_ram_chk.sv
module sp_tracked_ram_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned READ_LAT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              rd_nwr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  localparam int unsigned LAT = (READ_LAT < 1) ? 1 : READ_LAT;

  logic [LAT-1:0] pend;
  logic           due;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else if (LAT == 1) pend <= {{(LAT-1){1'b0}}, acc_en && rd_nwr};
    else pend <= {pend[LAT-2:0], acc_en && rd_nwr};
  end

  assign due = pend[LAT-1];

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !due |=> $stable(rd_valid));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!due && rd_valid) |=> $stable(rd_data));

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(due));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_valid);

  // R2
  no_early_chk: assert property (@(posedge clk) disable iff (rst)
    (!due && !rd_valid) |=> !rd_valid);
endmodule

bind sp_tracked_ram sp_tracked_ram_chk #(.DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .rd_nwr(rd_nwr),
  .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/tb_sp_tracked_ram.sv
module tb_sp_tracked_ram;
  localparam int unsigned DW  = 16;
  localparam int unsigned AW  = 6;
  localparam int unsigned LAT = 2;
  localparam int unsigned NV  = 8;

  // each vector: {address, data}; two regions, low and high half
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {6'd0,  16'hA5A5}, {6'd1,  16'h1234}, {6'd2,  16'hFFFF}, {6'd3,  16'h0001},
    {6'd40, 16'h8000}, {6'd41, 16'h0F0F}, {6'd42, 16'hC3C3}, {6'd63, 16'h7E57}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_en = 1'b0;
  logic          rd_nwr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sp_tracked_ram #(.DATA_W(DW), .ADDR_W(AW), .READ_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .rd_nwr(rd_nwr),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_en = 1'b1; rd_nwr = 1'b0; addr = a; wr_data = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  // drive at a falling edge, sample after the result edge
  task automatic rd(input logic [AW-1:0] a);
    acc_en = 1'b1; rd_nwr = 1'b1; addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    rst = 1'b0;
    @(negedge clk);
    check("R8", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});

    // R3 unwritten location before any write
    rd(6'd5);
    check("R3", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});

    // R1 R4 table walk: write both regions then read back
    for (int i = 0; i < NV; i++) wr(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][AW+DW-1:DW]);
      check("R1/R4", {rd_valid, rd_data}, {1'b1, VEC[i][DW-1:0]});
    end

    // R3 unwritten location in between written ones
    rd(6'd20);
    check("R3", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});

    // R2 timing: not one edge early, present at READ_LAT
    acc_en = 1'b1; rd_nwr = 1'b1; addr = 6'd41;
    @(negedge clk);
    acc_en = 1'b0;
    repeat (LAT-1) @(negedge clk);
    check("R2 early", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    @(negedge clk);
    check("R2", {rd_valid, rd_data}, {1'b1, 16'h0F0F});

    // R9 overwrite
    wr(6'd1, 16'hBEEF);
    rd(6'd1);
    check("R9", {rd_valid, rd_data}, {1'b1, 16'hBEEF});

    // R6 hold over idle cycles and a write access
    repeat (4) @(negedge clk);
    check("R6 idle", {rd_valid, rd_data}, {1'b1, 16'hBEEF});
    wr(6'd50, 16'h5555);
    repeat (LAT+1) @(negedge clk);
    check("R6 write", {rd_valid, rd_data}, {1'b1, 16'hBEEF});

    // R7 strobe low: nothing stored
    rd_nwr = 1'b0; addr = 6'd10; wr_data = 16'h9999;
    repeat (2) @(negedge clk);
    rd_nwr = 1'b0; addr = 6'd2; wr_data = 16'h0000;
    repeat (2) @(negedge clk);
    rd(6'd10);
    check("R7 unwritten", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    rd(6'd2);
    check("R7 kept", {rd_valid, rd_data}, {1'b1, 16'hFFFF});

    // R5 reset forgets written words
    rst = 1'b1;
    @(negedge clk);
    check("R8", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    rst = 1'b0;
    rd(6'd0);
    check("R5", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    rd(6'd63);
    check("R5", {rd_valid, {DW{1'b0}}}, {1'b0, {DW{1'b0}}});
    wr(6'd0, 16'h4242);
    rd(6'd0);
    check("R1 after reset", {rd_valid, rd_data}, {1'b1, 16'h4242});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule